// File: doc/BRIEF.md
# Reset-time option configuration loader

This block sits between the chip's external reset input and the CPU core. After the reset input is released it reads the 256-byte option area at the top of program memory, one byte per clock, through a synchronous read port with one cycle of latency. It stores the option bytes that matter in registers. From those registers it drives the per-pin output form and pull-up enables for ports 0, 1 and 3 to the pad logic.

The block holds the core in reset for a fixed settle period of `SETTLE_CYCLES` system clocks, about 3 ms at the target clock, so that the options reach the pads before any instruction runs. The core is then released with a start address of zero, and a done flag rises in the same cycle. The external reset input is asynchronous and passes through a two-flop synchroniser. If it is asserted again while loading is in progress, the block returns to its safe default (all pins open drain, no pull-ups) and the sweep begins again from the first option byte.

Top module: `opt_loader`

## Requirements
- R1: Counting from the first clock edge at which the synchronised reset is low, the block issues one read per cycle, `mem_rd_en` high, to addresses `AREA_BASE` (FF00h) up to FFFFh in ascending order. Each address is read exactly once and no further reads follow. Read data is taken one cycle after the read is issued.
- R2: Option byte offset 0 sets the port 0 output form. Bit i = 1 makes pin i CMOS (`p0_od[i]` = 0), and bit i = 0 makes it open drain (`p0_od[i]` = 1).
- R3: In option byte offset 1, bit 0 enables the pull-ups of port 0 pins 3..0 and bit 1 enables the pull-ups of pins 7..4. A value of 1 enables them, and the result appears on `p0_pu`.
- R4: Option byte offset 2 sets the port 1 output form. Bit i = 1 makes pin i CMOS (`p1_od[i]` = 0), and bit i = 0 makes it open drain.
- R5: In option byte offset 3, bit 0 controls port 3 pins 3..0 and bit 1 controls pins 7..4. A value of 1 selects CMOS output with the pull-up allowed (`p3_od` = 0, `p3_pu` = 1). A value of 0 selects open drain with the pull-up disabled.
- R6: A pin whose output form is open drain always has its pull-up enable low, whatever its pull-up option bit says.
- R7: Option bytes at offsets 4 to 255 have no effect on any output. Bits 7..2 of offsets 1 and 3 have no effect either.
- R8: `core_rst` stays high from reset until exactly `SETTLE_CYCLES` clock edges have passed, counting from the first edge at which the synchronised reset is low. The external input reaches the synchronised reset two edges after it changes. At that edge `core_rst` falls and `opt_done` rises in the same cycle, and both then keep their values until the next reset. `core_start_pc` is 0000h.
- R9: While the synchronised reset is active, and in the cycle after it, the outputs take their safe default: all `*_od` bits are 1, all `*_pu` bits are 0, `core_rst` is 1, `opt_done` is 0 and `mem_rd_en` is 0. If reset is asserted again during loading, the load is aborted, even on the edge that would capture an option byte, and the next load starts again from offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst | input | 1 | External reset, active high, asynchronous |
| mem_rd_en | output | 1 | Program memory read strobe |
| mem_addr | output | ADDR_W | Program memory read address |
| mem_rdata | input | PORT_W | Read data, valid one cycle after the strobe |
| core_rst | output | 1 | Holds the CPU core in reset while high |
| core_start_pc | output | ADDR_W | Start address for the core, always zero |
| opt_done | output | 1 | Options applied and core released |
| p0_od | output | PORT_W | Port 0 open-drain select per pin |
| p0_pu | output | PORT_W | Port 0 effective pull-up enable per pin |
| p1_od | output | PORT_W | Port 1 open-drain select per pin |
| p3_od | output | PORT_W | Port 3 open-drain select per pin |
| p3_pu | output | PORT_W | Port 3 pull-up permission per pin |

## Verification
A reset abort and an option-byte capture can fall on the same clock edge. The bench provokes this with a one-cycle pulse on `ext_rst`, timed so that the synchronised reset acts on the edge that would store the offset 3 byte. It judges the result by requiring every pin output to show the safe default in the following cycle. It then requires the restarted sweep to begin again at FF00h, with a fresh count of 256 reads, and to deliver the new option values. The settle expiry and the end of loading are also checked against each other: the release must come on exactly the expected edge, and not before the last byte has been taken in.

// File: rtl/opt_pkg.sv
package opt_pkg;
  // Byte offsets within the option area, decoded by the option registers
  localparam int unsigned OFS_P0_FORM = 0;
  localparam int unsigned OFS_P0_PULL = 1;
  localparam int unsigned OFS_P1_FORM = 2;
  localparam int unsigned OFS_P3_NIB  = 3;
  localparam int unsigned NIB_BITS    = 4;
endpackage

// File: rtl/opt_rst_sync.sv
module opt_rst_sync (
  input  logic clk,
  input  logic async_in,
  output logic rst_out
);
  logic [1:0] sync_q = 2'b11;

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[0], async_in};
  end

  assign rst_out = sync_q[1];
endmodule

// File: rtl/opt_fetch_seq.sv
module opt_fetch_seq #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned AREA_BASE  = 32'hFF00,
  parameter int unsigned AREA_BYTES = 256,
  localparam int unsigned OFS_W     = $clog2(AREA_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              rd_en,
  output logic [ADDR_W-1:0] addr,
  output logic              cap_vld,
  output logic [OFS_W-1:0]  cap_ofs,
  output logic              loaded
);
  localparam logic [OFS_W:0]    AREA_N = (OFS_W+1)'(AREA_BYTES);
  localparam logic [OFS_W-1:0]  LAST   = OFS_W'(AREA_BYTES - 1);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(AREA_BASE);

  logic [OFS_W:0]    iss_q;
  logic [OFS_W-1:0]  ofs_iss_q;
  logic              rd_en_q;
  logic [ADDR_W-1:0] addr_q;
  logic              vld_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              loaded_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_q     <= '0;
      ofs_iss_q <= '0;
      rd_en_q   <= 1'b0;
      addr_q    <= BASE_A;
      vld_q     <= 1'b0;
      ofs_q     <= '0;
      loaded_q  <= 1'b0;
    end else begin
      vld_q <= rd_en_q;
      ofs_q <= ofs_iss_q;
      if (iss_q < AREA_N) begin
        rd_en_q   <= 1'b1;
        addr_q    <= BASE_A + ADDR_W'(iss_q);
        ofs_iss_q <= iss_q[OFS_W-1:0];
        iss_q     <= iss_q + 1'b1;
      end else begin
        rd_en_q <= 1'b0;
      end
      if (vld_q && ofs_q == LAST) loaded_q <= 1'b1;
    end
  end

  assign rd_en   = rd_en_q;
  assign addr    = addr_q;
  assign cap_vld = vld_q;
  assign cap_ofs = ofs_q;
  assign loaded  = loaded_q;

  // R1: consecutive reads walk the area one address at a time
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (addr == $past(addr) + 1'b1));

  // R1: once the whole area has been taken in, no read is issued
  assert_reads_stop_R1: assert property (@(posedge clk) disable iff (rst)
    loaded |-> !rd_en);
endmodule

// File: rtl/opt_regs.sv
module opt_regs
  import opt_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_vld,
  input  logic [OFS_W-1:0]  cap_ofs,
  input  logic [PORT_W-1:0] cap_data,
  output logic [PORT_W-1:0] p0_od,
  output logic [PORT_W-1:0] p0_pu,
  output logic [PORT_W-1:0] p1_od,
  output logic [PORT_W-1:0] p3_od,
  output logic [PORT_W-1:0] p3_pu
);
  localparam int unsigned NIBS = PORT_W / NIB_BITS;

  logic [PORT_W-1:0] p0_cmos_q, p1_cmos_q;
  logic [NIBS-1:0]   p0_nib_q, p3_nib_q;
  logic [PORT_W-1:0] p0_pu_w, p3_cmos_w;
  logic              unused_hi;

  assign unused_hi = ^cap_data[PORT_W-1:NIBS];

  always_ff @(posedge clk) begin
    if (rst) begin
      p0_cmos_q <= '0;
      p1_cmos_q <= '0;
      p0_nib_q  <= '0;
      p3_nib_q  <= '0;
    end else if (cap_vld) begin
      if (cap_ofs == OFS_W'(OFS_P0_FORM)) p0_cmos_q <= cap_data;
      if (cap_ofs == OFS_W'(OFS_P0_PULL)) p0_nib_q  <= cap_data[NIBS-1:0];
      if (cap_ofs == OFS_W'(OFS_P1_FORM)) p1_cmos_q <= cap_data;
      if (cap_ofs == OFS_W'(OFS_P3_NIB))  p3_nib_q  <= cap_data[NIBS-1:0];
    end
  end

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign p0_pu_w[g*NIB_BITS +: NIB_BITS] =
      {NIB_BITS{p0_nib_q[g]}} & p0_cmos_q[g*NIB_BITS +: NIB_BITS];
    assign p3_cmos_w[g*NIB_BITS +: NIB_BITS] = {NIB_BITS{p3_nib_q[g]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p0_od <= '1;
      p0_pu <= '0;
      p1_od <= '1;
      p3_od <= '1;
      p3_pu <= '0;
    end else begin
      p0_od <= ~p0_cmos_q;
      p0_pu <= p0_pu_w;
      p1_od <= ~p1_cmos_q;
      p3_od <= ~p3_cmos_w;
      p3_pu <= p3_cmos_w;
    end
  end

  // R6: an open-drain pin never has its pull-up enabled
  assert_od_no_pullup_R6: assert property (@(posedge clk) disable iff (rst)
    ((p0_od & p0_pu) == '0) && ((p3_od & p3_pu) == '0));

  // R9: safe default follows any reset cycle
  assert_reset_default_R9: assert property (@(posedge clk)
    rst |=> ((&p0_od) && (&p1_od) && (&p3_od) && (p0_pu == '0) && (p3_pu == '0)));

  // R7: bytes beyond the decoded offsets leave the option state untouched
  assert_tail_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (cap_vld && cap_ofs > OFS_W'(OFS_P3_NIB)) |=>
      $stable({p0_cmos_q, p0_nib_q, p1_cmos_q, p3_nib_q}));
endmodule

// File: rtl/opt_settle.sv
module opt_settle #(
  parameter int unsigned SETTLE_CYCLES = 30000,
  localparam int unsigned CNT_W        = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic loaded,
  output logic core_rst,
  output logic done
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      core_rst <= 1'b1;
      done     <= 1'b0;
    end else begin
      if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LIM && loaded) begin
        core_rst <= 1'b0;
        done     <= 1'b1;
      end
    end
  end

  // R8: the core is never released before every option byte is in
  assert_hold_until_loaded_R8: assert property (@(posedge clk) disable iff (rst)
    !core_rst |-> loaded);

  // R8: once released the core stays released until the next reset
  assert_stay_released_R8: assert property (@(posedge clk) disable iff (rst)
    !core_rst |=> !core_rst);
endmodule

// File: rtl/opt_loader.sv
module opt_loader #(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned AREA_BASE     = 32'hFF00,
  parameter int unsigned AREA_BYTES    = 256,
  parameter int unsigned PORT_W        = 8,
  parameter int unsigned SETTLE_CYCLES = 30000
) (
  input  logic              clk,
  input  logic              ext_rst,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [PORT_W-1:0] mem_rdata,
  output logic              core_rst,
  output logic [ADDR_W-1:0] core_start_pc,
  output logic              opt_done,
  output logic [PORT_W-1:0] p0_od,
  output logic [PORT_W-1:0] p0_pu,
  output logic [PORT_W-1:0] p1_od,
  output logic [PORT_W-1:0] p3_od,
  output logic [PORT_W-1:0] p3_pu
);
  localparam int unsigned OFS_W      = $clog2(AREA_BYTES);
  localparam int unsigned MIN_SETTLE = AREA_BYTES + 3;
  localparam int unsigned SETTLE_EFF =
    (SETTLE_CYCLES > MIN_SETTLE) ? SETTLE_CYCLES : MIN_SETTLE;

  logic             rst;
  logic             cap_vld;
  logic [OFS_W-1:0] cap_ofs;
  logic             loaded;

  opt_rst_sync i_sync (
    .clk      (clk),
    .async_in (ext_rst),
    .rst_out  (rst)
  );

  opt_fetch_seq #(
    .ADDR_W     (ADDR_W),
    .AREA_BASE  (AREA_BASE),
    .AREA_BYTES (AREA_BYTES)
  ) i_fetch (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (mem_rd_en),
    .addr    (mem_addr),
    .cap_vld (cap_vld),
    .cap_ofs (cap_ofs),
    .loaded  (loaded)
  );

  opt_regs #(
    .PORT_W (PORT_W),
    .OFS_W  (OFS_W)
  ) i_regs (
    .clk      (clk),
    .rst      (rst),
    .cap_vld  (cap_vld),
    .cap_ofs  (cap_ofs),
    .cap_data (mem_rdata),
    .p0_od    (p0_od),
    .p0_pu    (p0_pu),
    .p1_od    (p1_od),
    .p3_od    (p3_od),
    .p3_pu    (p3_pu)
  );

  opt_settle #(
    .SETTLE_CYCLES (SETTLE_EFF)
  ) i_settle (
    .clk      (clk),
    .rst      (rst),
    .loaded   (loaded),
    .core_rst (core_rst),
    .done     (opt_done)
  );

  assign core_start_pc = '0;
endmodule

// File: tb/test_opt_loader.sv
module test_opt_loader;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 300;
  localparam int NVEC       = 5;

  // {b0, b1, b2, b3, fill, exp p0_od, exp p0_pu, exp p1_od, exp p3_od, exp p3_pu}
  localparam logic [79:0] VEC [NVEC] = '{
    {8'hFF, 8'h03, 8'hFF, 8'h03, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF},
    {8'h00, 8'h03, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00},
    {8'h0F, 8'h03, 8'hA5, 8'h01, 8'h5A, 8'hF0, 8'h0F, 8'h5A, 8'hF0, 8'h0F},
    {8'h3C, 8'h02, 8'h81, 8'h02, 8'hC3, 8'hC3, 8'h30, 8'h7E, 8'h0F, 8'hF0},
    {8'hFF, 8'hFC, 8'h00, 8'hFC, 8'h3B, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00}
  };

  logic        clk = 1'b0;
  logic        ext_rst = 1'b1;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic        core_rst, opt_done;
  logic [15:0] core_start_pc;
  logic [7:0]  p0_od, p0_pu, p1_od, p3_od, p3_pu;

  int n_chk = 0;
  int n_err = 0;
  int rd_count = 0;
  int addr_err = 0;
  logic [15:0] exp_addr = 16'hFF00;
  logic [7:0] cur_b0, cur_b1, cur_b2, cur_b3, cur_fill;

  always #(CLK_PERIOD/2) clk = ~clk;

  opt_loader #(.SETTLE_CYCLES(SETTLE)) i_opt_loader (
    .clk(clk), .ext_rst(ext_rst), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .core_rst(core_rst), .core_start_pc(core_start_pc),
    .opt_done(opt_done), .p0_od(p0_od), .p0_pu(p0_pu), .p1_od(p1_od),
    .p3_od(p3_od), .p3_pu(p3_pu)
  );

  function automatic logic [7:0] byte_at(logic [15:0] a);
    case (a[7:0])
      8'd0:    return cur_b0;
      8'd1:    return cur_b1;
      8'd2:    return cur_b2;
      8'd3:    return cur_b3;
      default: return cur_fill ^ a[7:0];
    endcase
  endfunction

  // Program memory model: one cycle read latency, checks the address order
  always @(posedge clk) begin
    if (mem_rd_en) begin
      if (mem_addr !== exp_addr) addr_err <= addr_err + 1;
      exp_addr  <= exp_addr + 16'd1;
      rd_count  <= rd_count + 1;
      mem_rdata <= byte_at(mem_addr);
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_bytes(input int v);
    cur_b0 = VEC[v][79:72]; cur_b1 = VEC[v][71:64];
    cur_b2 = VEC[v][63:56]; cur_b3 = VEC[v][55:48];
    cur_fill = VEC[v][47:40];
  endtask

  task automatic chk_pins(input int v);
    chk("R2 p0_od", {8'h00, p0_od}, {8'h00, VEC[v][39:32]});
    chk("R3 R6 R7 p0_pu", {8'h00, p0_pu}, {8'h00, VEC[v][31:24]});
    chk("R4 p1_od", {8'h00, p1_od}, {8'h00, VEC[v][23:16]});
    chk("R5 R7 p3_od", {8'h00, p3_od}, {8'h00, VEC[v][15:8]});
    chk("R5 R6 p3_pu", {8'h00, p3_pu}, {8'h00, VEC[v][7:0]});
  endtask

  task automatic chk_release(input int v);
    chk("R8 core_rst released", {15'd0, core_rst}, 16'd0);
    chk("R8 opt_done with release", {15'd0, opt_done}, 16'd1);
    chk("R8 core_start_pc", core_start_pc, 16'h0000);
    chk("R1 read count", 16'(rd_count), 16'd256);
    chk("R1 address order", 16'(addr_err), 16'd0);
    chk_pins(v);
  endtask

  task automatic run_load(input int v);
    set_bytes(v);
    @(negedge clk) ext_rst = 1'b1;
    repeat (4) @(negedge clk);
    rd_count = 0; addr_err = 0; exp_addr = 16'hFF00;
    ext_rst = 1'b0;
    repeat (SETTLE + 1) @(posedge clk);
    @(negedge clk);
    chk("R8 core_rst held one edge before", {15'd0, core_rst}, 16'd1);
    chk("R8 opt_done low before", {15'd0, opt_done}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    chk_release(v);
    repeat (3) @(negedge clk);
    chk("R1 no read after load", {15'd0, mem_rd_en}, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    cur_b0 = 8'h00; cur_b1 = 8'h00; cur_b2 = 8'h00; cur_b3 = 8'h00; cur_fill = 8'h00;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk("R9 reset p0_od", {8'h00, p0_od}, 16'h00FF);
    chk("R9 reset p0_pu", {8'h00, p0_pu}, 16'h0000);
    chk("R9 reset p1_od", {8'h00, p1_od}, 16'h00FF);
    chk("R9 reset p3_od/p3_pu", {p3_od, p3_pu}, 16'hFF00);
    chk("R9 reset core_rst/opt_done/rd", {13'd0, core_rst, opt_done, mem_rd_en}, 16'd4);

    for (int v = 0; v < NVEC; v++) run_load(v);

    // R9 abort colliding with capture of the offset 3 byte
    set_bytes(2);
    @(negedge clk) ext_rst = 1'b1;
    repeat (4) @(negedge clk);
    rd_count = 0; addr_err = 0; exp_addr = 16'hFF00;
    ext_rst = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) ext_rst = 1'b1;
    @(negedge clk) ext_rst = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R9 abort p0_od default", {8'h00, p0_od}, 16'h00FF);
    chk("R9 abort p0_pu default", {8'h00, p0_pu}, 16'h0000);
    chk("R9 abort p1_od default", {8'h00, p1_od}, 16'h00FF);
    chk("R9 abort p3 default", {p3_od, p3_pu}, 16'hFF00);
    chk("R9 abort core_rst/opt_done/rd", {13'd0, core_rst, opt_done, mem_rd_en}, 16'd4);
    set_bytes(3);
    rd_count = 0; addr_err = 0; exp_addr = 16'hFF00;
    repeat (SETTLE - 1) @(posedge clk);
    @(negedge clk);
    chk("R8 R9 core_rst held after restart", {15'd0, core_rst}, 16'd1);
    @(posedge clk);
    @(negedge clk);
    chk_release(3);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule